// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Drain Driver Register

This block turns a serial bit stream into eight parallel drive bits for low-side sink switches. Bits enter a shift chain on the rising edge of a shift clock. A separately clocked holding register snapshots the chain, so the loads change only when the holding clock rises. An active-low enable gates the held value onto the eight drain-enable outputs. A drive bit of 1 means its sink switch conducts, and 0 means it is off.

The last stage of the shift chain leaves the block as a cascade output. This output is re-timed on the falling edge of the shift clock, so the next device in a chain gets half a clock period of hold margin. That margin lets chained devices tolerate clock skew. A single active-low clear empties the shift chain, the holding register and the cascade output at once, without waiting for any clock edge.

Top module: `serial_drain_reg`

## Requirements
- R1: On each rising edge of `sh_clk`, every shift stage i (i ≥ 1) takes the old value of stage i-1, and stage 0 takes `ser_in`.
- R2: On each rising edge of `st_clk`, the holding register loads the shift stages. If both clocks rise in the same instant, it loads the stage contents from before that shift edge.
- R3: While `clr_n` is 0, the shift stages, the holding register and `cas_out` read 0. The clear acts without a clock edge, and edges on either clock have no effect until `clr_n` returns to 1.
- R4: While `oe_n` is 1, all bits of `drain_on` are 0, whatever the holding register holds.
- R5: While `oe_n` is 0, `drain_on[i]` equals held stage i. A value of 1 means sink on. A byte shifted in most-significant bit first therefore appears unchanged on `drain_on`.
- R6: `cas_out` presents the last shift stage and changes only on the falling edge of `sh_clk`. A rising edge of `sh_clk` leaves it unchanged.
- R7: The first bit shifted in after a clear reaches `cas_out` at the falling edge that follows its eighth rising shift edge.
- R8: Two devices chained from `cas_out` to `ser_in` hold a 16-bit word correctly when the second device's shift clock lags the first by less than half a period. The second device holds the first eight bits sent.
- R9: Shift edges without a holding-clock edge leave `drain_on` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data into shift stage 0 |
| sh_clk | input | 1 | Shift clock; rising edge shifts, falling edge updates `cas_out` |
| st_clk | input | 1 | Holding-register clock, rising edge |
| clr_n | input | 1 | Active-low clear of all state, asynchronous |
| oe_n | input | 1 | Active-low output enable |
| drain_on | output | WIDTH | Sink-switch enables, 1 = conducting |
| cas_out | output | 1 | Cascade serial output, last stage re-timed on the falling edge |

## Verification
Single bytes with mixed bits (0xA5), all zeros, all ones and a lone 1 are shifted in most-significant bit first and then latched. A swapped or reversed stage order shows as a wrong drain pattern. A holding edge placed on the shift edge is set against one placed in mid-phase, which tells a pre-edge capture from a post-edge capture. Further cases toggle the enable over stored data, assert clear partway through a byte with both clocks still running, and send a 16-bit word through a skewed pair. The skewed pair is the case that fails if the cascade output were driven on the rising edge.

// File: rtl/serial_drain_pkg.sv
package serial_drain_pkg;
  // Which shift-clock edge re-times the cascade output.
  typedef enum logic {
    CAS_ON_FALL = 1'b0,
    CAS_ON_RISE = 1'b1
  } cas_edge_e;
endpackage

// File: rtl/sdr_shift.sv
module sdr_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         din,
  output logic [W-1:0] q
);
  // Stage 0 takes the serial input; each higher stage takes its lower neighbour.
  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q[i] <= 1'b0;
        else        q[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q[i] <= 1'b0;
        else        q[i] <= q[i-1];
      end
    end
  end
endmodule

// File: rtl/sdr_hold.sv
module sdr_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/sdr_cascade.sv
module sdr_cascade
  import serial_drain_pkg::*;
#(
  parameter cas_edge_e MODE = CAS_ON_FALL
) (
  input  logic clk,
  input  logic clr_n,
  input  logic last_stage,
  output logic cas
);
  if (MODE == CAS_ON_FALL) begin : g_fall
    always_ff @(negedge clk or negedge clr_n) begin
      if (!clr_n) cas <= 1'b0;
      else        cas <= last_stage;
    end
  end else begin : g_rise
    assign cas = last_stage;
  end
endmodule

// File: rtl/sdr_gate.sv
module sdr_gate #(
  parameter int W = 8
) (
  input  logic         off,
  input  logic [W-1:0] held,
  output logic [W-1:0] drv
);
  always_comb begin
    for (int i = 0; i < W; i++) drv[i] = held[i] & ~off;
  end
endmodule

// File: rtl/serial_drain_reg.sv
module serial_drain_reg
  import serial_drain_pkg::*;
#(
  parameter int        WIDTH    = 8,
  parameter cas_edge_e CAS_MODE = CAS_ON_FALL
) (
  input  logic             ser_in,
  input  logic             sh_clk,
  input  logic             st_clk,
  input  logic             clr_n,
  input  logic             oe_n,
  output logic [WIDTH-1:0] drain_on,
  output logic             cas_out
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] store_q;

  sdr_shift #(.W(WIDTH)) u_shift (
    .clk   (sh_clk),
    .clr_n (clr_n),
    .din   (ser_in),
    .q     (shift_q)
  );

  sdr_hold #(.W(WIDTH)) u_hold (
    .clk   (st_clk),
    .clr_n (clr_n),
    .d     (shift_q),
    .q     (store_q)
  );

  sdr_cascade #(.MODE(CAS_MODE)) u_cas (
    .clk        (sh_clk),
    .clr_n      (clr_n),
    .last_stage (shift_q[LAST]),
    .cas        (cas_out)
  );

  sdr_gate #(.W(WIDTH)) u_gate (
    .off  (oe_n),
    .held (store_q),
    .drv  (drain_on)
  );
endmodule

// File: rtl/serial_drain_reg_chk.sv
module serial_drain_reg_chk
  import serial_drain_pkg::*;
#(
  parameter int        W        = 8,
  parameter cas_edge_e CAS_MODE = CAS_ON_FALL
) (
  input logic         sh_clk,
  input logic         st_clk,
  input logic         clr_n,
  input logic         oe_n,
  input logic         ser_in,
  input logic [W-1:0] sr_q,
  input logic [W-1:0] st_q,
  input logic [W-1:0] drain_on,
  input logic         cas_out
);
  // Each flag records a clear seen since the previous edge of its own clock,
  // so a clear pulse between edges masks the step-to-step relation.
  logic sh_clr_seen, st_clr_seen, neg_clr_seen;

  always_ff @(posedge sh_clk or negedge clr_n)
    if (!clr_n) sh_clr_seen <= 1'b1; else sh_clr_seen <= 1'b0;
  always_ff @(posedge st_clk or negedge clr_n)
    if (!clr_n) st_clr_seen <= 1'b1; else st_clr_seen <= 1'b0;
  always_ff @(negedge sh_clk or negedge clr_n)
    if (!clr_n) neg_clr_seen <= 1'b1; else neg_clr_seen <= 1'b0;

  p_shift_in_r1: assert property (@(posedge sh_clk) disable iff (!clr_n)
    1'b1 |=> (sh_clr_seen || sr_q[0] == $past(ser_in)));

  p_shift_move_r1: assert property (@(posedge sh_clk) disable iff (!clr_n)
    1'b1 |=> (sh_clr_seen || sr_q[W-1:1] == $past(sr_q[W-2:0])));

  p_store_r2: assert property (@(posedge st_clk) disable iff (!clr_n)
    1'b1 |=> (st_clr_seen || st_q == $past(sr_q)));

  p_clear_r3: assert property (@(posedge sh_clk)
    !clr_n |-> (sr_q == '0 && st_q == '0 && !cas_out));

  p_oe_off_r4: assert property (@(posedge sh_clk) disable iff (!clr_n)
    oe_n |-> drain_on == '0);

  p_pass_r5: assert property (@(posedge sh_clk) disable iff (!clr_n)
    !oe_n |-> drain_on == st_q);

  if (CAS_MODE == CAS_ON_FALL) begin : g_cas_chk
    p_cas_fall_r6: assert property (@(negedge sh_clk) disable iff (!clr_n)
      1'b1 |=> (neg_clr_seen || cas_out == $past(sr_q[W-1])));
  end
endmodule

bind serial_drain_reg serial_drain_reg_chk #(.W(WIDTH), .CAS_MODE(CAS_MODE)) u_chk (
  .sh_clk   (sh_clk),
  .st_clk   (st_clk),
  .clr_n    (clr_n),
  .oe_n     (oe_n),
  .ser_in   (ser_in),
  .sr_q     (shift_q),
  .st_q     (store_q),
  .drain_on (drain_on),
  .cas_out  (cas_out)
);

// File: tb/serial_drain_reg_tb.sv
module serial_drain_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int SKEW = 4;

  logic sh_clk = 1'b0, shb_clk = 1'b0, st_clk = 1'b0;
  logic clr_n = 1'b0, oe_n = 1'b1, ser_in = 1'b0, casc_in = 1'b0;
  logic skew_v;
  logic [W-1:0] drain, drain_a, drain_b;
  logic cas, cas_a, cas_b;
  int n_tests = 0, n_fail = 0;

  // Behavioural reference: queues with index 0 = newest bit.
  bit m_sr[$], m_a[$], m_b[$];
  logic [31:0] m_st, m_sta, m_stb;
  bit m_cas, m_casa, m_casb;

  serial_drain_reg #(.WIDTH(W)) u_dut (
    .ser_in(ser_in), .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n),
    .oe_n(oe_n), .drain_on(drain), .cas_out(cas));
  serial_drain_reg #(.WIDTH(W)) u_casc_a (
    .ser_in(casc_in), .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n),
    .oe_n(oe_n), .drain_on(drain_a), .cas_out(cas_a));
  serial_drain_reg #(.WIDTH(W)) u_casc_b (
    .ser_in(cas_a), .sh_clk(shb_clk), .st_clk(st_clk), .clr_n(clr_n),
    .oe_n(oe_n), .drain_on(drain_b), .cas_out(cas_b));

  always #(CLK_PERIOD/2) sh_clk = ~sh_clk;
  always begin
    @(sh_clk);
    skew_v = sh_clk;
    #SKEW;
    shb_clk = skew_v;
  end

  function automatic logic [31:0] q2int(input bit q[$]);
    logic [31:0] r = '0;
    for (int i = 0; i < W; i++) r[i] = q[i];
    return r;
  endfunction

  task automatic zq(ref bit q[$]);
    q.delete();
    repeat (W) q.push_back(1'b0);
  endtask

  task automatic push_bit(ref bit q[$], input bit b);
    q.push_front(b);
    void'(q.pop_back());
  endtask

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(oe_n ? "R4" : "R5", 32'(drain), oe_n ? 32'd0 : m_st, "drain");
    check("R6", 32'(cas), 32'(m_cas), "cascade out");
    check("R8", 32'(drain_a), oe_n ? 32'd0 : m_sta, "chain A drain");
    check("R8", 32'(drain_b), oe_n ? 32'd0 : m_stb, "chain B drain");
    check("R8", 32'(cas_b), 32'(m_casb), "chain B cascade");
  endtask

  // One shift cycle, entered just after a falling edge.
  // stm: 0 = no holding edge, 1 = holding edge on the shift edge, 2 = mid-phase.
  task automatic tick(input bit b, input bit cb, input int stm);
    bit old_casa;
    ser_in = b;
    casc_in = cb;
    @(posedge sh_clk);
    m_casb = m_b[W-1];
    old_casa = m_casa;
    if (stm == 1) begin
      st_clk = 1'b1;
      m_st = q2int(m_sr); m_sta = q2int(m_a); m_stb = q2int(m_b);
    end
    push_bit(m_sr, b);
    push_bit(m_a, cb);
    #1;
    check("R6", 32'(cas), 32'(m_cas), "cascade steady over rising edge");
    st_clk = 1'b0;
    if (stm == 2) begin
      #1 st_clk = 1'b1;
      m_st = q2int(m_sr); m_sta = q2int(m_a); m_stb = q2int(m_b);
      #1 st_clk = 1'b0;
    end
    push_bit(m_b, old_casa);
    @(negedge sh_clk);
    m_cas = m_sr[W-1];
    m_casa = m_a[W-1];
    #1 compare_all();
  endtask

  task automatic shift_byte(input logic [7:0] v, input int last_stm);
    for (int i = 7; i >= 0; i--) tick(v[i], 1'b0, (i == 0) ? last_stm : 0);
  endtask

  task automatic zero_models();
    zq(m_sr); zq(m_a); zq(m_b);
    m_st = '0; m_sta = '0; m_stb = '0;
    m_cas = 1'b0; m_casa = 1'b0; m_casb = 1'b0;
  endtask

  // Entered just after a falling edge; clear held across a shift and a holding edge.
  task automatic do_clear();
    ser_in = 1'b1;
    casc_in = 1'b1;
    clr_n = 1'b0;
    zero_models();
    #1;
    check("R3", 32'(drain), 32'd0, "drain right after async clear");
    check("R3", 32'(cas), 32'd0, "cascade right after async clear");
    compare_all();
    @(posedge sh_clk);
    #1 st_clk = 1'b1;
    #1 st_clk = 1'b0;
    @(negedge sh_clk);
    #1;
    check("R3", 32'(drain), 32'd0, "drain after clocks under clear");
    check("R3", 32'(cas), 32'd0, "cascade after clocks under clear");
    compare_all();
    clr_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    zero_models();
    @(negedge sh_clk);
    #1;
    check("R3", 32'(drain), 32'd0, "reset drain, disabled");
    check("R3", 32'(cas), 32'd0, "reset cascade");
    oe_n = 1'b0;
    #1 check("R3", 32'(drain), 32'd0, "reset drain, enabled");
    clr_n = 1'b1;

    // R1 R5 R7: mixed byte, latched mid-phase after the eighth bit
    shift_byte(8'hA5, 2);
    check("R1", 32'(drain), 32'hA5, "byte 0xA5 order");
    check("R7", 32'(cas), 32'd1, "first bit at cascade after 8 shifts");

    // R9: further shifts without a holding edge
    tick(1'b0, 1'b0, 0); tick(1'b1, 1'b0, 0); tick(1'b1, 1'b0, 0);
    check("R9", 32'(drain), 32'hA5, "drain held across shifts");

    // R4 then R5: enable toggled over stored data
    oe_n = 1'b1;
    tick(1'b0, 1'b0, 0);
    check("R4", 32'(drain), 32'd0, "disabled drains off");
    oe_n = 1'b0;
    tick(1'b0, 1'b0, 0);
    check("R5", 32'(drain), 32'hA5, "re-enabled drains restored");

    // R2: holding edge on the shift edge takes the pre-edge contents
    shift_byte(8'h3C, 0);
    tick(1'b1, 1'b0, 1);
    check("R2", 32'(drain), 32'h3C, "simultaneous edges load old stages");

    // R3: clear in the middle of a byte, then recovery
    tick(1'b1, 1'b1, 0); tick(1'b0, 1'b1, 0); tick(1'b1, 1'b0, 0);
    do_clear();
    check("R3", 32'(drain), 32'd0, "held value gone after clear");
    shift_byte(8'h81, 2);
    check("R1", 32'(drain), 32'h81, "byte 0x81 after clear");

    // R1: plain patterns
    shift_byte(8'hFF, 2);
    check("R1", 32'(drain), 32'hFF, "all ones");
    shift_byte(8'h00, 2);
    check("R1", 32'(drain), 32'h00, "all zeros");
    shift_byte(8'h01, 2);
    check("R1", 32'(drain), 32'h01, "lone low bit");
    check("R7", 32'(cas), 32'd0, "cascade shows oldest bit of 0x01");

    // R8: 16-bit word through the skewed pair, word 0xC35A MSB first
    do_clear();
    for (int i = 15; i >= 0; i--) tick(1'b0, 16'hC35A >> i, 0);
    tick(1'b0, 1'b0, 1);
    check("R8", 32'(drain_a), 32'h5A, "near device low byte");
    check("R8", 32'(drain_b), 32'hC3, "far device high byte");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule